// File: doc/BRIEF.md
# Hypercube Packet Router Node

This block is one vertex of a four-dimensional binary hypercube network of sixteen routers. Each router owns a 4-bit node address and serves a local group of sixteen processing elements. A processing element is named by an 8-bit address: the upper four bits select the router and the lower four bits select the element behind it. The router takes packets from its local elements through an inject port and sends them into the network. It hands packets meant for its own group to an eject port and passes every other packet one hop closer to its target.

Each of the five inputs (four dimension links plus local inject) feeds a 4-entry FIFO. The head of each FIFO is routed by XOR of the destination's router bits with the node address. An all-zero difference selects the eject port. Otherwise the lowest set bit of the difference names the dimension link to cross. This fixed dimension order produces minimal paths and rules out cyclic waits. Each of the five outputs has its own round-robin arbiter that grants one input per cycle. Every link crossing increments a hop field in the packet, so a delivered packet carries the number of hops it took.

All ports use valid/ready handshakes. The router address is a static input and is held constant during operation.

Top module: `hcube_router`

## Requirements
- R1: A packet is one 27-bit flit: destination address in bits [7:0], source address in bits [15:8], payload in bits [23:16] and hop count in bits [26:24]. In each address the router part is the upper four bits and the element index is the lower four bits.
- R2: A packet whose destination router bits equal `node_addr` leaves on the eject port with destination, source and payload unchanged.
- R3: A packet for another router leaves on link d, where d is the lowest bit position in which the destination router bits and `node_addr` differ. Link d connects to the router whose address differs only in bit d.
- R4: Each departure on a dimension link adds one to the hop field. At its destination a packet's hop count equals the Hamming distance between its source router and its destination router.
- R5: The hop field of a packet accepted on the inject port is cleared to zero, whatever value is driven. Injected packets carry this router's address as their source router bits.
- R6: Each input holds up to four packets. Its ready output is low exactly when four are held, and no accepted packet is lost or duplicated.
- R7: When several inputs compete for one output, grants rotate round-robin, so two inputs that keep requesting are served alternately.
- R8: While an output has valid high and ready low, its valid stays high and its data stays unchanged on the next cycle.
- R9: During and right after reset, all output valids are low and all input readies are high.
- R10: Packets that enter through one input and leave through one output keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_addr | input | 4 | This router's address, held static |
| lnk_in_valid | input | 4 | Valid of each incoming dimension link |
| lnk_in_data | input | 108 | Packets on the incoming links, link d in bits [27d+26:27d] |
| lnk_in_ready | output | 4 | Ready of each incoming link |
| lnk_out_valid | output | 4 | Valid of each outgoing dimension link |
| lnk_out_data | output | 108 | Packets on the outgoing links, link d in bits [27d+26:27d] |
| lnk_out_ready | input | 4 | Ready of each outgoing link |
| inj_valid | input | 1 | Local inject valid |
| inj_data | input | 27 | Local inject packet |
| inj_ready | output | 1 | Local inject ready |
| ej_valid | output | 1 | Local eject valid |
| ej_data | output | 27 | Local eject packet |
| ej_ready | input | 1 | Local eject ready |

## Verification
The bench builds a full sixteen-node cube from instances of the block and tries routing with a table of source/destination pairs. The table covers a local pair (distance 0), single-bit pairs and pairs that differ in all four bits, so a wrong hop count or a wrong delivery node stands out directly. It injects with a nonzero hop field to show that injection clears it, and it watches the first link taken from node 0 to tell lowest-dimension-first routing from any other order. Directed patterns cover the remaining cases: stalled ejection that fills an inject FIFO (ready, hold and order), two neighbours contending for one eject port (alternation), and six simultaneous senders converging on one node (no loss, correct hop counts under contention).

// File: rtl/hcr_pkg.sv
// Shared constants and the packet type of the hypercube router.
// Assumes a binary hypercube in which node addresses are DIMS bits wide.
package hcr_pkg;
    localparam int DIMS   = 4;
    localparam int LIDX_W = 4;
    localparam int NODE_W = DIMS;
    localparam int ADDR_W = NODE_W + LIDX_W;
    localparam int PAY_W  = 8;
    localparam int HOP_W  = $clog2(DIMS + 1);

    typedef struct packed {
        logic [HOP_W-1:0]  hops;
        logic [PAY_W-1:0]  payload;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } pkt_t;

    localparam int PKT_W = $bits(pkt_t);
endpackage

// File: rtl/hcr_fifo.sv
// Small synchronous FIFO used on every router input.
// Pushes while full and pops while empty are dropped; the head is shown
// combinationally from storage.
module hcr_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/hcr_route.sv
// Output selection for one FIFO head.
// Dimension-order rule: eject when the router bits match, otherwise the
// lowest differing address bit names the link. Output is one-hot over
// DIMS links plus the eject port (MSB).
module hcr_route
    import hcr_pkg::*;
(
    input  logic              valid,
    input  logic [NODE_W-1:0] self_node,
    input  logic [NODE_W-1:0] dst_node,
    output logic [DIMS:0]     req
);
    logic [NODE_W-1:0] diff, lowbit;

    assign diff   = self_node ^ dst_node;
    assign lowbit = diff & ((~diff) + NODE_W'(1));

    // Pick the eject port or the lowest differing dimension.
    always_comb begin
        req = '0;
        if (valid) begin
            if (diff == '0) req[DIMS] = 1'b1;
            else            req[DIMS-1:0] = lowbit;
        end
    end
endmodule

// File: rtl/hcr_rr_arb.sv
// Round-robin arbiter for one router output.
// The search starts one past the last input served. While the output is
// stalled (hold), the grant is frozen so valid and data stay put.
module hcr_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         hold,
    input  logic         adv,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr;
    logic [N-1:0]  held, rr_gnt;
    logic          locked;
    int            g_idx;

    // Rotating search for the first requester at or after the pointer.
    always_comb begin
        int  idx;
        logic found;
        rr_gnt = '0;
        found  = 1'b0;
        idx    = 0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(ptr) + i) % N;
            if (!found && req[idx]) begin
                rr_gnt[idx] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    assign gnt = locked ? held : rr_gnt;

    // Index of the current grant, for the pointer update.
    always_comb begin
        g_idx = 0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) g_idx = i;
        end
    end

    // Pointer advance on transfer and grant freeze on stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            locked <= 1'b0;
            held   <= '0;
        end else begin
            if (adv) ptr <= (g_idx == N - 1) ? '0 : PW'(g_idx + 1);
            locked <= hold;
            held   <= gnt;
        end
    end
endmodule

// File: rtl/hcube_router.sv
// One vertex of a binary hypercube packet network.
// Five inputs (DIMS links plus local inject) each feed a FIFO; each head
// is routed in dimension order and five round-robin arbiters serve the
// outputs (DIMS links plus local eject). Link departures increment the
// hop field; injection clears it. Assumes node_addr is static.
module hcube_router
    import hcr_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NODE_W-1:0]      node_addr,
    input  logic [DIMS-1:0]        lnk_in_valid,
    input  logic [DIMS*PKT_W-1:0]  lnk_in_data,
    output logic [DIMS-1:0]        lnk_in_ready,
    output logic [DIMS-1:0]        lnk_out_valid,
    output logic [DIMS*PKT_W-1:0]  lnk_out_data,
    input  logic [DIMS-1:0]        lnk_out_ready,
    input  logic                   inj_valid,
    input  logic [PKT_W-1:0]       inj_data,
    output logic                   inj_ready,
    output logic                   ej_valid,
    output logic [PKT_W-1:0]       ej_data,
    input  logic                   ej_ready
);
    localparam int NIN  = DIMS + 1;
    localparam int NOUT = DIMS + 1;
    localparam int LOC  = DIMS;

    logic [NIN-1:0]                in_v, in_rdy, h_v, pop;
    logic [NIN-1:0][PKT_W-1:0]     in_d, h_d;
    logic [NIN-1:0][NOUT-1:0]      req_m;
    logic [NOUT-1:0][NIN-1:0]      req_c, gnt_m;
    logic [NOUT-1:0]               o_v, o_r;
    logic [NOUT-1:0][PKT_W-1:0]    o_d;

    // Input side: source select, FIFO and route per input.
    for (genvar i = 0; i < NIN; i++) begin : g_in
        logic full_w, empty_w;
        pkt_t head;

        if (i < LOC) begin : g_link
            assign in_v[i]         = lnk_in_valid[i];
            assign in_d[i]         = lnk_in_data[i*PKT_W +: PKT_W];
            assign lnk_in_ready[i] = in_rdy[i];
        end else begin : g_inj
            assign in_v[i]   = inj_valid;
            assign in_d[i]   = {HOP_W'(0), inj_data[PKT_W-HOP_W-1:0]};
            assign inj_ready = in_rdy[i];
        end

        hcr_fifo #(.W(PKT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_v[i]),
            .din   (in_d[i]),
            .full  (full_w),
            .pop   (pop[i]),
            .dout  (h_d[i]),
            .empty (empty_w)
        );

        assign in_rdy[i] = !full_w;
        assign h_v[i]    = !empty_w;
        assign head      = pkt_t'(h_d[i]);

        hcr_route u_route (
            .valid     (h_v[i]),
            .self_node (node_addr),
            .dst_node  (head.dst[ADDR_W-1:LIDX_W]),
            .req       (req_m[i])
        );
    end

    // Transpose requests into one column per output.
    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            for (int i = 0; i < NIN; i++) begin
                req_c[o][i] = req_m[i][o];
            end
        end
    end

    // Pop an input when its granted output completes a transfer.
    always_comb begin
        pop = '0;
        for (int i = 0; i < NIN; i++) begin
            for (int o = 0; o < NOUT; o++) begin
                if (gnt_m[o][i] && o_r[o]) pop[i] = 1'b1;
            end
        end
    end

    // Output side: arbiter, data select and hop update per output.
    for (genvar o = 0; o < NOUT; o++) begin : g_out
        logic [PKT_W-1:0] sel;
        pkt_t             pk;

        hcr_rr_arb #(.N(NIN)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_c[o]),
            .hold  (o_v[o] && !o_r[o]),
            .adv   (o_v[o] && o_r[o]),
            .gnt   (gnt_m[o])
        );

        assign o_v[o] = |gnt_m[o];

        // One-hot mux of the granted head.
        always_comb begin
            sel = '0;
            for (int i = 0; i < NIN; i++) begin
                if (gnt_m[o][i]) sel = sel | h_d[i];
            end
        end

        if (o < LOC) begin : g_link
            always_comb begin
                pk      = pkt_t'(sel);
                pk.hops = pk.hops + HOP_W'(1);
            end
            assign o_d[o]                       = pk;
            assign lnk_out_valid[o]             = o_v[o];
            assign lnk_out_data[o*PKT_W +: PKT_W] = o_d[o];
            assign o_r[o]                       = lnk_out_ready[o];
        end else begin : g_ej
            assign pk       = pkt_t'(sel);
            assign o_d[o]   = pk;
            assign ej_valid = o_v[o];
            assign ej_data  = o_d[o];
            assign o_r[o]   = ej_ready;
        end
    end
endmodule

// File: rtl/hcube_router_chk.sv
// Property checker for hcube_router, bound to every instance.
// Assumes packets arriving on links followed dimension order from a
// source router that injected them.
module hcube_router_chk
    import hcr_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic [NODE_W-1:0]     node_addr,
    input logic [DIMS-1:0]       lnk_out_valid,
    input logic [DIMS*PKT_W-1:0] lnk_out_data,
    input logic [DIMS-1:0]       lnk_out_ready,
    input logic                  ej_valid,
    input logic [PKT_W-1:0]      ej_data,
    input logic                  ej_ready
);
    pkt_t e_p;
    assign e_p = pkt_t'(ej_data);

    // Eject carries only packets for this router.
    p_local_eject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid |-> (e_p.dst[ADDR_W-1:LIDX_W] == node_addr));

    // Delivered hop count equals source-to-here distance.
    p_hops_eject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid |-> (int'(e_p.hops) == $countones(e_p.src[ADDR_W-1:LIDX_W] ^ node_addr)));

    // Stalled eject holds.
    p_hold_eject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid && !ej_ready |=> ej_valid && $stable(ej_data));

    for (genvar d = 0; d < DIMS; d++) begin : g_lnk
        pkt_t              l_p;
        logic [NODE_W-1:0] l_diff;
        assign l_p    = pkt_t'(lnk_out_data[d*PKT_W +: PKT_W]);
        assign l_diff = l_p.dst[ADDR_W-1:LIDX_W] ^ node_addr;

        // Link d used only when bit d is the lowest differing bit.
        p_route_dim_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lnk_out_valid[d] |-> (l_diff[d] && ((l_diff & NODE_W'((1 << d) - 1)) == '0)));

        // One more hop than the distance already covered.
        p_hops_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
            lnk_out_valid[d] |-> (int'(l_p.hops) == $countones(l_p.src[ADDR_W-1:LIDX_W] ^ node_addr) + 1));

        // Stalled link output holds.
        p_hold_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
            lnk_out_valid[d] && !lnk_out_ready[d] |=> lnk_out_valid[d] && $stable(lnk_out_data[d*PKT_W +: PKT_W]));
    end
endmodule

bind hcube_router hcube_router_chk u_chk (.*);

// File: tb/sim_hcube_router.sv
// Bench: a full 16-node cube of routers, table-driven routing checks
// followed by directed stall, arbitration and contention tests.
module sim_hcube_router;
    import hcr_pkg::*;

    localparam int NR = 1 << DIMS;
    localparam int LOGN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NR-1:0][DIMS-1:0]       lin_v, lin_r, lout_v, lout_r;
    logic [NR-1:0][DIMS*PKT_W-1:0] lin_d, lout_d;
    logic [NR-1:0]                 inj_v, inj_rdy, ej_v, ej_rdy;
    logic [NR-1:0][PKT_W-1:0]      inj_d, ej_d;

    for (genvar r = 0; r < NR; r++) begin : g_node
        for (genvar d = 0; d < DIMS; d++) begin : g_w
            localparam int NB = r ^ (1 << d);
            assign lin_v[r][d]                  = lout_v[NB][d];
            assign lin_d[r][d*PKT_W +: PKT_W]   = lout_d[NB][d*PKT_W +: PKT_W];
            assign lout_r[r][d]                 = lin_r[NB][d];
        end
        hcube_router u0 (
            .clk           (clk),
            .rst_n         (rst_n),
            .node_addr     (NODE_W'(r)),
            .lnk_in_valid  (lin_v[r]),
            .lnk_in_data   (lin_d[r]),
            .lnk_in_ready  (lin_r[r]),
            .lnk_out_valid (lout_v[r]),
            .lnk_out_data  (lout_d[r]),
            .lnk_out_ready (lout_r[r]),
            .inj_valid     (inj_v[r]),
            .inj_data      (inj_d[r]),
            .inj_ready     (inj_rdy[r]),
            .ej_valid      (ej_v[r]),
            .ej_data       (ej_d[r]),
            .ej_ready      (ej_rdy[r])
        );
    end

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // Delivery log filled by the eject monitor.
    int         log_n = 0;
    int         log_node [LOGN];
    logic [PKT_W-1:0] log_pkt [LOGN];

    always @(negedge clk) begin
        for (int r = 0; r < NR; r++) begin
            if (rst_n && ej_v[r] && ej_rdy[r] && log_n < LOGN) begin
                log_node[log_n] = r;
                log_pkt[log_n]  = ej_d[r];
                log_n = log_n + 1;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic inject(input int r, input logic [7:0] src, input logic [7:0] dst,
                          input logic [7:0] pay, input logic [2:0] h);
        @(negedge clk);
        inj_d[r] = {h, pay, src, dst};
        inj_v[r] = 1'b1;
        while (!inj_rdy[r]) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        inj_v[r] = 1'b0;
    endtask

    task automatic wait_log(input int target, input string req);
        int t = 0;
        while (log_n < target && t < 200) begin
            @(posedge clk);
            t++;
        end
        chk(log_n >= target, req, "deliveries", log_n, target);
    endtask

    // {src, dst, payload}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'hF3, 8'h11},
        {8'h35, 8'h3A, 8'h22},
        {8'h5C, 8'hA1, 8'h33},
        {8'h10, 8'h20, 8'h44},
        {8'h8F, 8'h0E, 8'h55},
        {8'hC4, 8'h34, 8'h66},
        {8'h69, 8'h6D, 8'h77},
        {8'hE7, 8'h18, 8'h88}
    };

    initial begin
        int s;
        inj_v  = '0;
        inj_d  = '0;
        ej_rdy = '1;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ej_v == '0, "R9", "eject valid in reset", int'(ej_v), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ej_v == '0 && lout_v == '0, "R9", "valids after reset", int'(ej_v), 0);
        chk(inj_rdy == '1 && lin_r == '1, "R9", "readies after reset", int'(inj_rdy), 16'hFFFF);

        // R3: first link from node 0 is the lowest differing dimension
        s = log_n;
        inject(0, 8'h00, 8'hF0, 8'hA0, 3'd0);
        chk(lout_v[0] == 4'b0001, "R3", "first hop toward F", int'(lout_v[0]), 1);
        wait_log(s + 1, "R3");
        s = log_n;
        inject(0, 8'h00, 8'hE0, 8'hA1, 3'd0);
        chk(lout_v[0] == 4'b0010, "R3", "first hop toward E", int'(lout_v[0]), 2);
        wait_log(s + 1, "R3");

        // R1 R2 R4 R5: table walk, injected with a nonzero hop field
        foreach (VEC[k]) begin
            logic [7:0] vs, vd, vp;
            pkt_t got;
            int   hx;
            vs = VEC[k][23:16];
            vd = VEC[k][15:8];
            vp = VEC[k][7:0];
            hx = $countones(vs[7:4] ^ vd[7:4]);
            s  = log_n;
            inject(int'(vs[7:4]), vs, vd, vp, 3'd5);
            wait_log(s + 1, "R2");
            got = pkt_t'(log_pkt[s]);
            chk(log_node[s] == int'(vd[7:4]) && got.dst == vd && got.src == vs
                && got.payload == vp, "R1/R2", "delivery node", log_node[s], int'(vd[7:4]));
            chk(int'(got.hops) == hx, "R4/R5", "hop count", int'(got.hops), hx);
        end

        // R6 R8 R10: stall eject at node 5, fill its inject FIFO
        ej_rdy[5] = 1'b0;
        s = log_n;
        for (int k = 0; k < 4; k++) inject(5, 8'h50, 8'h57, 8'(8'h40 + k), 3'd0);
        chk(inj_rdy[5] == 1'b0, "R6", "inject ready when full", int'(inj_rdy[5]), 0);
        chk(ej_v[5] && ej_d[5][23:16] == 8'h40, "R8", "stalled head", int'(ej_d[5][23:16]), 'h40);
        @(negedge clk);
        chk(ej_v[5] && ej_d[5][23:16] == 8'h40, "R8", "stalled head held", int'(ej_d[5][23:16]), 'h40);
        ej_rdy[5] = 1'b1;
        wait_log(s + 4, "R6");
        for (int k = 0; k < 4; k++)
            chk(log_pkt[s+k][23:16] == 8'(8'h40 + k), "R10", "order",
                int'(log_pkt[s+k][23:16]), 'h40 + k);

        // R7: neighbours 1 and 2 compete for eject at node 0
        ej_rdy[0] = 1'b0;
        s = log_n;
        inject(1, 8'h10, 8'h00, 8'hB0, 3'd0);
        inject(1, 8'h10, 8'h00, 8'hB1, 3'd0);
        inject(2, 8'h20, 8'h00, 8'hC0, 3'd0);
        inject(2, 8'h20, 8'h00, 8'hC1, 3'd0);
        repeat (10) @(negedge clk);
        ej_rdy[0] = 1'b1;
        wait_log(s + 4, "R7");
        for (int k = 0; k < 3; k++)
            chk(log_pkt[s+k][15:12] != log_pkt[s+k+1][15:12], "R7", "alternating source",
                int'(log_pkt[s+k+1][15:12]), -1);

        // R6 R4: six senders converge on node 0 at once
        s = log_n;
        fork
            inject(1,  8'h10, 8'h01, 8'hD1, 3'd0);
            inject(2,  8'h20, 8'h02, 8'hD2, 3'd0);
            inject(4,  8'h40, 8'h03, 8'hD4, 3'd0);
            inject(8,  8'h80, 8'h04, 8'hD8, 3'd0);
            inject(3,  8'h30, 8'h05, 8'hD3, 3'd0);
            inject(15, 8'hF0, 8'h06, 8'hDF, 3'd0);
        join
        wait_log(s + 6, "R6");
        for (int k = 0; k < 6; k++) begin
            logic [7:0] want;
            int hx, hit, hop;
            case (k)
                0: want = 8'hD1; 1: want = 8'hD2; 2: want = 8'hD4;
                3: want = 8'hD8; 4: want = 8'hD3; default: want = 8'hDF;
            endcase
            hx  = $countones(want[3:0]);
            hit = 0;
            hop = -1;
            for (int j = s; j < log_n; j++) begin
                if (log_pkt[j][23:16] == want && log_node[j] == 0) begin
                    hit = hit + 1;
                    hop = int'(log_pkt[j][26:24]);
                end
            end
            chk(hit == 1, "R6", "converging packet delivered once", hit, 1);
            chk(hop == hx, "R4", "converging hop count", hop, hx);
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule